// File: doc/BRIEF.md
# Bit Set/Clear Port Sequencer

This block is the host-side driver for a board of lamp latches. It holds a 16-byte shadow image of every lamp state. Commands arrive as a 2-bit opcode and a bit index. A set or clear command changes one bit of one shadow byte. The block then sends that whole byte to the receiver as a five-step write sequence on an 8-bit data bus and a 2-bit control field. In that sequence the data byte goes out first and the latch address after it. A clear-all command first drives the control field to its idle value, then zeroes the whole image and sends every byte out, lowest first. A combinational read port returns any shadow byte at any time.

The controller is a single state machine. Its states are `ST_IDLE`, `ST_PREP`, `ST_DATA`, `ST_STB0`, `ST_ADDR`, `ST_STB3` and `ST_STB1`. An accepted set or clear moves `ST_IDLE` to `ST_DATA`. An accepted clear-all moves `ST_IDLE` to `ST_PREP`. When a step's hold time expires, the machine moves `ST_PREP` to `ST_DATA`, then `ST_DATA` to `ST_STB0`, `ST_STB0` to `ST_ADDR`, `ST_ADDR` to `ST_STB3` and `ST_STB3` to `ST_STB1`. From `ST_STB1` it returns to `ST_DATA` while a clear-all sweep still has bytes left to send, and otherwise to `ST_IDLE`. Every bus step lasts `step_hold + 1` clock cycles. The bench holds `step_hold` constant while `busy` is high.

Top module: `bitlamp_seq`

## Requirements
- R1: Opcode 2'b01 (set) with index i < 128 ORs the mask `8'h80 >> (i % 8)` into shadow byte `i / 8`. Bit position 0 is therefore the MSB.
- R2: Opcode 2'b10 (clear) with index i < 128 ANDs shadow byte `i / 8` with the complement of the same mask.
- R3: After a set or clear, the bus steps run in this order: `bus_data` takes the updated byte; `bus_ctrl` becomes 0; `bus_data` takes the address; `bus_ctrl` becomes 3; `bus_ctrl` becomes 1. Apart from these changes, `bus_ctrl` keeps its idle value of 1.
- R4: The address byte for byte number b is b + 8 when b is 0 to 7, and (b − 8) + 16 when b is 8 to 15.
- R5: Each bus step holds its value for `step_hold + 1` clock cycles. The first step is driven at the clock edge that accepts the command.
- R6: Opcode 2'b11 (clear-all) ignores the index. It first writes `bus_ctrl` = 1 for one step, then zeroes all 16 shadow bytes and sends each byte, value 0, in ascending order using the R3 sequence.
- R7: Opcode 2'b00 is rejected. `cmd_err` goes high for exactly one cycle after the accepting edge, `busy` stays low, and the shadow image, `bus_data` and `bus_ctrl` do not change.
- R8: A set or clear with index ≥ 128 is rejected in the same way as R7.
- R9: `busy` rises at the edge that accepts a command and falls one cycle after the last step of the sequence ends. A `cmd_valid` that arrives while `busy` is high is ignored.
- R10: `rd_data` shows shadow byte `rd_sel` combinationally.
- R11: After reset, `busy` = 0, `cmd_err` = 0, `bus_data` = 0, `bus_ctrl` = 1, and every shadow byte is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 01 set, 10 clear, 11 clear-all, 00 illegal |
| cmd_index | input | 8 | Lamp bit index |
| step_hold | input | 4 | Extra cycles each bus step is held |
| rd_sel | input | 4 | Shadow byte to read |
| rd_data | output | 8 | Selected shadow byte |
| bus_data | output | 8 | Data/address bus to the receiver |
| bus_ctrl | output | 2 | Control field to the receiver |
| busy | output | 1 | Sequence in progress |
| cmd_err | output | 1 | One-cycle reject pulse |

## Verification
A wrong state in this block shows up on the ports within one step. A skipped or reordered state puts a wrong (data, control) pair on the bus in that step's first cycle. A wrong byte counter sends a wrong address in step three of the same byte. A bad mask or update corrupts `rd_data` and the next data step at once. The bench compares every cycle of every sequence against an arithmetic model, and it reads back the whole shadow image after each sweep.

// File: rtl/bls_pkg.sv
package bls_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_DATA,
        ST_STB0,
        ST_ADDR,
        ST_STB3,
        ST_STB1
    } bls_state_t;

    localparam logic [1:0] OP_SET = 2'b01;
    localparam logic [1:0] OP_CLR = 2'b10;
    localparam logic [1:0] OP_ALL = 2'b11;

    localparam logic [1:0] CTRL_IDLE  = 2'd1;
    localparam logic [1:0] CTRL_LATCH = 2'd0;
    localparam logic [1:0] CTRL_STEER = 2'd3;
endpackage

// File: rtl/bls_shadow.sv
module bls_shadow #(
    parameter int NBYTES = 16,
    localparam int SEL_W = $clog2(NBYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_all,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [SEL_W-1:0] rd_a_sel,
    output logic [7:0]       rd_a,
    input  logic [SEL_W-1:0] rd_b_sel,
    output logic [7:0]       rd_b
);
    logic [7:0] mem_q [NBYTES];

    always_ff @(posedge clk) begin
        for (int i = 0; i < NBYTES; i++) begin
            if (!rst_n || clr_all) begin
                mem_q[i] <= 8'h00;
            end else if (wr_en && wr_sel == SEL_W'(i)) begin
                mem_q[i] <= wr_data;
            end
        end
    end

    assign rd_a = mem_q[rd_a_sel];
    assign rd_b = mem_q[rd_b_sel];
endmodule

// File: rtl/bls_step_timer.sv
module bls_step_timer #(
    parameter int HOLD_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] hold,
    output logic              done
);
    logic [HOLD_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= hold;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);
endmodule

// File: rtl/bitlamp_seq.sv
module bitlamp_seq
    import bls_pkg::*;
#(
    parameter int NBYTES = 16,
    parameter int HOLD_W = 4,
    parameter int IDX_W  = 8,
    localparam int SEL_W = $clog2(NBYTES),
    localparam int LINES = NBYTES * 8,
    localparam int BANK_SZ = 8,
    localparam int BANK0_BASE = 8,
    localparam int BANK1_BASE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [IDX_W-1:0]  cmd_index,
    input  logic [HOLD_W-1:0] step_hold,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [7:0]        rd_data,
    output logic [7:0]        bus_data,
    output logic [1:0]        bus_ctrl,
    output logic              busy,
    output logic              cmd_err
);
    bls_state_t       state_q, state_d;
    logic [SEL_W-1:0] byte_q, byte_d;
    logic             sweep_q, sweep_d;
    logic             idle, op_ok, idx_ok, accept, reject, step_done, step_adv;
    logic [SEL_W-1:0] cmd_byte;
    logic [7:0]       mask, cur_byte, new_byte, data_val, addr_val;

    assign idle     = (state_q == ST_IDLE);
    assign op_ok    = (cmd_op != 2'b00);
    assign idx_ok   = (cmd_op == OP_ALL) || (int'(cmd_index) < LINES);
    assign accept   = cmd_valid && idle && op_ok && idx_ok;
    assign reject   = cmd_valid && idle && !(op_ok && idx_ok);
    assign cmd_byte = cmd_index[3 +: SEL_W];
    assign mask     = 8'h80 >> cmd_index[2:0];
    assign new_byte = (cmd_op == OP_SET) ? (cur_byte | mask) : (cur_byte & ~mask);
    assign step_adv = accept || (!idle && step_done);

    bls_shadow #(.NBYTES(NBYTES)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_all  (accept && cmd_op == OP_ALL),
        .wr_en    (accept && cmd_op != OP_ALL),
        .wr_sel   (cmd_byte),
        .wr_data  (new_byte),
        .rd_a_sel (byte_d),
        .rd_a     (cur_byte),
        .rd_b_sel (rd_sel),
        .rd_b     (rd_data)
    );

    bls_step_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (step_adv),
        .hold  (step_hold),
        .done  (step_done)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        byte_d  = byte_q;
        sweep_d = sweep_q;
        unique case (state_q)
            ST_IDLE: if (accept) begin
                sweep_d = (cmd_op == OP_ALL);
                byte_d  = (cmd_op == OP_ALL) ? '0 : cmd_byte;
                state_d = (cmd_op == OP_ALL) ? ST_PREP : ST_DATA;
            end
            ST_PREP: if (step_done) state_d = ST_DATA;
            ST_DATA: if (step_done) state_d = ST_STB0;
            ST_STB0: if (step_done) state_d = ST_ADDR;
            ST_ADDR: if (step_done) state_d = ST_STB3;
            ST_STB3: if (step_done) state_d = ST_STB1;
            ST_STB1: if (step_done) begin
                if (sweep_q && byte_q != SEL_W'(NBYTES - 1)) begin
                    byte_d  = byte_q + 1'b1;
                    state_d = ST_DATA;
                end else begin
                    sweep_d = 1'b0;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            byte_q  <= '0;
            sweep_q <= 1'b0;
        end else begin
            state_q <= state_d;
            byte_q  <= byte_d;
            sweep_q <= sweep_d;
        end
    end

    assign data_val = idle ? new_byte : cur_byte;
    assign addr_val = (int'(byte_d) < BANK_SZ)
                    ? 8'(BANK0_BASE + int'(byte_d))
                    : 8'(BANK1_BASE + int'(byte_d) - BANK_SZ);

    // bus output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_data <= 8'h00;
            bus_ctrl <= CTRL_IDLE;
            cmd_err  <= 1'b0;
        end else begin
            cmd_err <= reject;
            if (step_adv) begin
                unique case (state_d)
                    ST_PREP: bus_ctrl <= CTRL_IDLE;
                    ST_DATA: bus_data <= data_val;
                    ST_STB0: bus_ctrl <= CTRL_LATCH;
                    ST_ADDR: bus_data <= addr_val;
                    ST_STB3: bus_ctrl <= CTRL_STEER;
                    ST_STB1: bus_ctrl <= CTRL_IDLE;
                    default: ;
                endcase
            end
        end
    end

    assign busy = !idle;

    // R3: control code 2 never appears on the bus
    p_ctrl_legal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ctrl != 2'd2);

    // R3: the steer code is only reached from the latch code
    p_steer_after_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ctrl == CTRL_STEER && $past(bus_ctrl) != CTRL_STEER) |-> $past(bus_ctrl) == CTRL_LATCH);

    // R9: bus is quiet while idle
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(bus_data) && $stable(bus_ctrl)));

    // R9: busy only rises on a presented command
    p_busy_from_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(cmd_valid));

    // R7: a reject never starts a sequence
    p_err_no_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> !busy);

    // R7: reject pulse lasts a single cycle
    p_err_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |=> !cmd_err || $past(cmd_valid));
endmodule

// File: tb/bitlamp_seq_test.sv
module bitlamp_seq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [7:0] cmd_index = 8'd0;
    logic [3:0] step_hold = 4'd0;
    logic [3:0] rd_sel = 4'd0;
    logic [7:0] rd_data, bus_data;
    logic [1:0] bus_ctrl;
    logic       busy, cmd_err;

    int checks = 0;
    int errors = 0;
    logic [7:0] mdl [16];
    logic [7:0] last_data = 8'h00;

    always #10 clk = ~clk;

    bitlamp_seq uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_index(cmd_index), .step_hold(step_hold), .rd_sel(rd_sel),
        .rd_data(rd_data), .bus_data(bus_data), .bus_ctrl(bus_ctrl),
        .busy(busy), .cmd_err(cmd_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] addr_of(input int b);
        return (b < 8) ? 8'(b + 8) : 8'(b - 8 + 16);
    endfunction

    task automatic check_image(input string req);
        for (int b = 0; b < 16; b++) begin
            rd_sel = 4'(b);
            #1;
            check(rd_data == mdl[b], req, rd_data, mdl[b]);
        end
    endtask

    // accepted command: model update, then cycle-by-cycle trace compare
    task automatic run_cmd(input logic [1:0] op, input int idx, input int h, input bit intrude);
        int b, steps, total, bad_i, s, k, bi;
        logic [7:0] ed, dv;
        logic [1:0] ec;
        bit mism;
        string tag;
        @(negedge clk);
        step_hold = 4'(h); cmd_valid = 1'b1; cmd_op = op; cmd_index = 8'(idx);
        @(negedge clk);
        cmd_valid = 1'b0;
        b = idx / 8;
        if (op == 2'b01) begin mdl[b] = mdl[b] | (8'h80 >> (idx % 8)); tag = "R1 R3 R4 R5 trace"; end
        else if (op == 2'b10) begin mdl[b] = mdl[b] & ~(8'h80 >> (idx % 8)); tag = "R2 R3 R4 R5 trace"; end
        else begin for (int j = 0; j < 16; j++) mdl[j] = 8'h00; tag = "R6 R5 sweep trace"; end
        steps = (op == 2'b11) ? 81 : 5;
        total = steps * (h + 1);
        mism = 1'b0; bad_i = 0;
        for (int i = 0; i < total; i++) begin
            k = i / (h + 1);
            if (op == 2'b11 && k == 0) begin
                ed = last_data; ec = 2'd1;
            end else begin
                if (op == 2'b11) k = k - 1;
                bi = (op == 2'b11) ? k / 5 : b;
                dv = (op == 2'b11) ? 8'h00 : mdl[b];
                s = k % 5;
                case (s)
                    0: begin ed = dv; ec = 2'd1; end
                    1: begin ed = dv; ec = 2'd0; end
                    2: begin ed = addr_of(bi); ec = 2'd0; end
                    3: begin ed = addr_of(bi); ec = 2'd3; end
                    default: begin ed = addr_of(bi); ec = 2'd1; end
                endcase
            end
            if (!mism && (bus_data !== ed || bus_ctrl !== ec || busy !== 1'b1)) begin
                mism = 1'b1; bad_i = i;
                $display("FAIL %s cycle %0d actual=%0h/%0h/%0b expected=%0h/%0h/1",
                         tag, i, bus_data, bus_ctrl, busy, ed, ec);
            end
            if (intrude && i == 1) begin
                cmd_valid = 1'b1; cmd_op = 2'b10; cmd_index = 8'(idx);
            end
            if (intrude && i == 2) cmd_valid = 1'b0;
            @(negedge clk);
        end
        checks++;
        if (mism) errors++;
        last_data = (op == 2'b11) ? addr_of(15) : addr_of(b);
        check(busy == 1'b0 && bus_ctrl == 2'd1, "R9 busy falls after last step", busy, 0);
        rd_sel = 4'(b);
        #1;
        check(rd_data == mdl[b], "R10 R9 byte after command", rd_data, mdl[b]);
    endtask

    task automatic run_reject(input logic [1:0] op, input int idx, input string req);
        logic [7:0] d0;
        logic [1:0] c0;
        d0 = bus_data; c0 = bus_ctrl;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_index = 8'(idx);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_err == 1'b1 && busy == 1'b0, req, {cmd_err, busy}, 2'b10);
        @(negedge clk);
        check(cmd_err == 1'b0 && busy == 1'b0 && bus_data == d0 && bus_ctrl == c0,
              req, {bus_data, bus_ctrl}, {d0, c0});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog expired actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int j = 0; j < 16; j++) mdl[j] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check(busy == 0 && cmd_err == 0, "R11 reset flags", {busy, cmd_err}, 0);
        check(bus_data == 8'h00 && bus_ctrl == 2'd1, "R11 reset bus", {bus_data, bus_ctrl}, 10'h001);
        check_image("R11 reset image");

        // R1 set sweep over every index, hold 0, intrusions exercise R9
        for (int i = 0; i < 128; i++) run_cmd(2'b01, i, 0, (i % 16) == 5);
        check_image("R1 image after set sweep");

        // R2 clear odd indices, hold 1
        for (int i = 1; i < 128; i += 2) run_cmd(2'b10, i, 1, 1'b0);
        check_image("R2 image after clear sweep");

        // R7 R8 rejects
        run_reject(2'b00, 3, "R7 illegal opcode");
        run_reject(2'b01, 128, "R8 index 128");
        run_reject(2'b10, 200, "R8 index 200");
        run_reject(2'b01, 255, "R8 index 255");
        check_image("R7 R8 image unchanged");

        // R5 longer hold, both address banks (R4)
        run_cmd(2'b01, 127, 3, 1'b0);
        run_cmd(2'b10, 0, 3, 1'b0);
        run_cmd(2'b01, 64, 2, 1'b0);

        // R6 clear-all
        run_cmd(2'b11, 77, 2, 1'b0);
        check_image("R6 image after clear-all");
        run_cmd(2'b11, 0, 0, 1'b1);
        check_image("R6 second clear-all");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule